// File: doc/BRIEF.md
# SPI DMA Burst Length Planner

This block splits a transfer of 64-bit words into SPI bursts that a DMA engine can move in equal-sized DMA bursts. Software or a control sequencer loads the total word count once. After that, each start pulse asks the block to plan the next SPI burst. The block answers with three values: the chunk length in words, the DMA burst length to use for that chunk, and the number of DMA bursts the chunk contains. At the same clock edge it subtracts the chunk from the remaining count. When nothing is left, done is raised.

Several rules pick the chunk:

- A remainder that fits in the FIFO goes out whole, as a single DMA burst.
- Very long remainders are capped at the largest chunk the burst counter allows.
- Any other remainder is sent whole if some burst length from 8 down to 2 divides it exactly. The planner checks one candidate per clock while busy is high.
- If no candidate divides it, the chunk is cut to a multiple of 8.

Every cut is chosen so that the words left afterwards are never a single word. A single word could not start a DMA burst.

Top module: `spi_burst_planner`

## Requirements
- R1: When the remaining count is no larger than fifo_depth_i, the plan is chunk = remaining, burst length = remaining, burst count = 1. The plan_valid_o pulse is visible in the cycle right after the clock edge that samples start_i.
- R2: When the remaining count is at least MAX_CHUNK = 8 × 65535 = 524280 and is not MAX_CHUNK + 1, the plan is chunk = MAX_CHUNK with burst length 8.
- R3: When the remaining count is exactly MAX_CHUNK + 1, the plan is chunk = MAX_CHUNK − 8 with burst length 8.
- R4: Otherwise the largest burst length k, taken from 8 down to 2, with remaining mod k = 0 is chosen, and chunk = remaining.
- R5: When no k in 2..8 divides the remaining count, chunk = remaining − (remaining mod 8), minus a further 8 when that remainder is 1. The burst length is 8.
- R6: burst_cnt_o equals the chunk divided by the burst length, rounded up.
- R7: remain_o drops by exactly the chunk at the edge that raises plan_valid_o. done_o is high exactly when remain_o is zero, which includes after reset.
- R8: Loading a total below 2 sets err_o and done_o, with remain_o = 0. Loading a total of 2 or more clears err_o. When load_i and start_i are both high in an idle cycle, load_i wins.
- R9: busy_o is high while the divisor search runs. start_i and load_i are ignored while busy_o is high. start_i is also ignored when remain_o is zero.
- R10: After any plan, remain_o is never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Latch total_i as the new remaining count |
| total_i | input | LEN_W | Total transfer length in words |
| fifo_depth_i | input | DEPTH_W | FIFO depth in words |
| start_i | input | 1 | Request the plan for the next SPI burst |
| busy_o | output | 1 | Divisor search in progress |
| plan_valid_o | output | 1 | One-cycle pulse: a new plan is on the outputs |
| chunk_o | output | LEN_W | Words in the planned SPI burst |
| burst_len_o | output | DEPTH_W | DMA burst length for the chunk |
| burst_cnt_o | output | LEN_W | DMA bursts in the chunk |
| remain_o | output | LEN_W | Words still to plan |
| done_o | output | 1 | No words remain |
| err_o | output | 1 | Last loaded total was below 2 |

## Verification
The assertions assume three things about the inputs:

- fifo_depth_i holds steady while a transfer is being planned.
- fifo_depth_i is at least 2.
- Every loaded total fits in LEN_W bits.

These assumptions are what keep the burst length and the count products inside their widths. The stimulus holds fifo_depth_i constant from each load until done. It draws depths between 4 and 64 and lengths from a few words up to twice the maximum chunk. Directed cases cover the MAX_CHUNK + 1 boundary, tails of one modulo 8, prime lengths, and commands issued while busy.

// File: rtl/burst_plan_pkg.sv
// Shared types for the SPI burst planner.
package burst_plan_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_SEARCH
    } plan_state_e;
endpackage

// File: rtl/bpl_divisibility.sv
// Flags, for every candidate burst length k in MIN_K..MAX_K, whether the
// remaining word count is an exact multiple of k.
// Assumes: MIN_K >= 2; each candidate is a constant divisor.
module bpl_divisibility #(
    parameter int LEN_W = 24,
    parameter int MIN_K = 2,
    parameter int MAX_K = 8
) (
    input  logic [LEN_W-1:0] rem_i,
    output logic [MAX_K:0]   hit_o
);
    // One constant-modulo test per candidate; entries below MIN_K stay low.
    for (genvar k = 0; k <= MAX_K; k++) begin : g_cand
        if (k < MIN_K) begin : g_off
            assign hit_o[k] = 1'b0;
        end else begin : g_on
            assign hit_o[k] = ((rem_i % LEN_W'(k)) == '0);
        end
    end
endmodule

// File: rtl/bpl_count.sv
// Computes the number of DMA bursts in a chunk: ceil(chunk / burst).
// Assumes: the burst length is either a candidate in MIN_K..MAX_K or
// equal to the chunk (one burst).
module bpl_count #(
    parameter int LEN_W   = 24,
    parameter int DEPTH_W = 8,
    parameter int MIN_K   = 2,
    parameter int MAX_K   = 8
) (
    input  logic [LEN_W-1:0]   chunk_i,
    input  logic [DEPTH_W-1:0] burst_i,
    output logic [LEN_W-1:0]   cnt_o
);
    logic [LEN_W-1:0] quo [MAX_K+1];

    // Rounded-up quotient for each constant candidate.
    for (genvar k = 0; k <= MAX_K; k++) begin : g_quo
        if (k < MIN_K) begin : g_off
            assign quo[k] = '0;
        end else begin : g_on
            assign quo[k] = (chunk_i + LEN_W'(k - 1)) / LEN_W'(k);
        end
    end

    // Select the quotient of the active burst length; otherwise a single burst.
    always_comb begin
        cnt_o = (chunk_i == '0) ? '0 : LEN_W'(1);
        for (int k = MIN_K; k <= MAX_K; k++) begin
            if (burst_i == DEPTH_W'(k) && chunk_i != LEN_W'(k)) cnt_o = quo[k];
        end
    end
endmodule

// File: rtl/spi_burst_planner.sv
// Plans SPI bursts for a DMA transfer of 64-bit words. A load latches the
// total length; each start plans one chunk and its DMA burst length and
// subtracts the chunk from the remaining count. The divisor search visits
// one candidate per cycle with busy_o high.
// Assumes: fifo_depth_i >= 2 and stable during a transfer.
module spi_burst_planner #(
    parameter int LEN_W     = 24,
    parameter int DEPTH_W   = 8,
    parameter int CNT_W     = 16,
    parameter int DEF_BURST = 8,
    parameter int MIN_BURST = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LEN_W-1:0]   total_i,
    input  logic [DEPTH_W-1:0] fifo_depth_i,
    input  logic               start_i,
    output logic               busy_o,
    output logic               plan_valid_o,
    output logic [LEN_W-1:0]   chunk_o,
    output logic [DEPTH_W-1:0] burst_len_o,
    output logic [LEN_W-1:0]   burst_cnt_o,
    output logic [LEN_W-1:0]   remain_o,
    output logic               done_o,
    output logic               err_o
);
    import burst_plan_pkg::*;

    localparam int CAND_W    = $clog2(DEF_BURST + 1);
    localparam int MAX_CHUNK = DEF_BURST * ((1 << CNT_W) - 1);
    localparam logic [LEN_W-1:0] MAX_L  = LEN_W'(MAX_CHUNK);
    localparam logic [LEN_W-1:0] DEF_L  = LEN_W'(DEF_BURST);

    plan_state_e         state_q;
    logic [CAND_W-1:0]   cand_q;
    logic [LEN_W-1:0]    remain_q;
    logic [LEN_W-1:0]    chunk_q;
    logic [DEPTH_W-1:0]  burst_q;
    logic                valid_q;
    logic                err_q;

    logic [DEF_BURST:0]  hit;
    logic                commit;
    logic                go_search;
    logic [LEN_W-1:0]    c_chunk;
    logic [DEPTH_W-1:0]  c_burst;
    logic [LEN_W-1:0]    tail;
    logic                idle_start;

    bpl_divisibility #(
        .LEN_W (LEN_W),
        .MIN_K (MIN_BURST),
        .MAX_K (DEF_BURST)
    ) u_div (
        .rem_i (remain_q),
        .hit_o (hit)
    );

    bpl_count #(
        .LEN_W   (LEN_W),
        .DEPTH_W (DEPTH_W),
        .MIN_K   (MIN_BURST),
        .MAX_K   (DEF_BURST)
    ) u_cnt (
        .chunk_i (chunk_q),
        .burst_i (burst_q),
        .cnt_o   (burst_cnt_o)
    );

    assign tail       = remain_q % DEF_L;
    assign idle_start = (state_q == ST_IDLE) && !load_i && start_i && (remain_q != '0);

    // Decide whether this cycle commits a plan, and which one.
    always_comb begin
        commit    = 1'b0;
        go_search = 1'b0;
        c_chunk   = remain_q;
        c_burst   = DEPTH_W'(DEF_BURST);
        if (idle_start) begin
            if (remain_q <= LEN_W'(fifo_depth_i)) begin
                commit  = 1'b1;
                c_burst = remain_q[DEPTH_W-1:0];
            end else if (remain_q == MAX_L + LEN_W'(1)) begin
                commit  = 1'b1;
                c_chunk = MAX_L - DEF_L;
            end else if (remain_q >= MAX_L) begin
                commit  = 1'b1;
                c_chunk = MAX_L;
            end else begin
                go_search = 1'b1;
            end
        end else if (state_q == ST_SEARCH) begin
            if (hit[cand_q]) begin
                commit  = 1'b1;
                c_burst = DEPTH_W'(cand_q);
            end else if (cand_q == CAND_W'(MIN_BURST)) begin
                commit  = 1'b1;
                c_chunk = remain_q - tail - ((tail == LEN_W'(1)) ? DEF_L : '0);
            end
        end
    end

    // Sequencer: load, search stepping and plan registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cand_q   <= '0;
            remain_q <= '0;
            chunk_q  <= '0;
            burst_q  <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            valid_q <= commit;
            if (state_q == ST_IDLE && load_i) begin
                err_q    <= (total_i < LEN_W'(2));
                remain_q <= (total_i < LEN_W'(2)) ? '0 : total_i;
            end
            if (go_search) begin
                state_q <= ST_SEARCH;
                cand_q  <= CAND_W'(DEF_BURST);
            end else if (state_q == ST_SEARCH && !commit) begin
                cand_q <= cand_q - CAND_W'(1);
            end
            if (commit) begin
                state_q  <= ST_IDLE;
                chunk_q  <= c_chunk;
                burst_q  <= c_burst;
                remain_q <= remain_q - c_chunk;
            end
        end
    end

    assign busy_o       = (state_q == ST_SEARCH);
    assign plan_valid_o = valid_q;
    assign chunk_o      = chunk_q;
    assign burst_len_o  = burst_q;
    assign remain_o     = remain_q;
    assign done_o       = (remain_q == '0);
    assign err_o        = err_q;

    logic [2*LEN_W-1:0] prod_hi;
    logic [2*LEN_W-1:0] prod_lo;
    assign prod_hi = (2*LEN_W)'(burst_cnt_o) * (2*LEN_W)'(burst_q);
    assign prod_lo = (2*LEN_W)'(burst_cnt_o - LEN_W'(1)) * (2*LEN_W)'(burst_q);

    p_decrement_r7: assert property (@(posedge clk) disable iff (!rst_n)
        plan_valid_o |-> remain_q == $past(remain_q) - chunk_q);

    p_remain_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!plan_valid_o && !$past(load_i && state_q == ST_IDLE)) |-> $stable(remain_q));

    p_no_single_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        plan_valid_o |-> remain_q != LEN_W'(1));

    p_burst_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        plan_valid_o |-> (chunk_q == LEN_W'(burst_q)) ||
                         (burst_q >= DEPTH_W'(MIN_BURST) && burst_q <= DEPTH_W'(DEF_BURST)));

    p_count_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        plan_valid_o |-> (prod_hi >= (2*LEN_W)'(chunk_q)) && (prod_lo < (2*LEN_W)'(chunk_q)));

    p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    p_busy_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !plan_valid_o);
endmodule

// File: tb/spi_burst_planner_tb.sv
module spi_burst_planner_tb;
    localparam int LEN_W   = 24;
    localparam int DEPTH_W = 8;
    localparam int unsigned MAXC = 8 * 65535;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               load_i;
    logic [LEN_W-1:0]   total_i;
    logic [DEPTH_W-1:0] fifo_depth_i;
    logic               start_i;
    logic               busy_o, plan_valid_o, done_o, err_o;
    logic [LEN_W-1:0]   chunk_o, burst_cnt_o, remain_o;
    logic [DEPTH_W-1:0] burst_len_o;

    int checks = 0;
    int errors = 0;
    int unsigned lat;

    spi_burst_planner u_dut (
        .clk (clk), .rst_n (rst_n), .load_i (load_i), .total_i (total_i),
        .fifo_depth_i (fifo_depth_i), .start_i (start_i), .busy_o (busy_o),
        .plan_valid_o (plan_valid_o), .chunk_o (chunk_o), .burst_len_o (burst_len_o),
        .burst_cnt_o (burst_cnt_o), .remain_o (remain_o), .done_o (done_o), .err_o (err_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference plan computed from the requirements.
    function automatic void ref_plan(input int unsigned rem, input int unsigned fifo,
                                     output int unsigned ch, output int unsigned bu,
                                     output int unsigned cn, output string tag);
        int unsigned t;
        if (rem <= fifo) begin
            ch = rem; bu = rem; tag = "R1";
        end else if (rem == MAXC + 1) begin
            ch = MAXC - 8; bu = 8; tag = "R3";
        end else if (rem >= MAXC) begin
            ch = MAXC; bu = 8; tag = "R2";
        end else begin
            tag = "R5"; bu = 0;
            for (int k = 8; k >= 2; k--) begin
                if (bu == 0 && rem % k == 0) bu = k;
            end
            if (bu != 0) begin
                ch = rem; tag = "R4";
            end else begin
                t = rem % 8; bu = 8;
                ch = rem - t - ((t == 1) ? 8 : 0);
            end
        end
        cn = (ch + bu - 1) / bu;
    endfunction

    task automatic do_load(input int unsigned tot);
        @(negedge clk); load_i = 1'b1; total_i = LEN_W'(tot);
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_valid();
        lat = 0;
        while (!plan_valid_o && lat < 40) begin
            @(posedge clk); #1; lat++;
        end
    endtask

    task automatic plan_and_check();
        int unsigned ch, bu, cn, rem;
        string tag;
        rem = remain_o;
        ref_plan(rem, fifo_depth_i, ch, bu, cn, tag);
        do_start();
        wait_valid();
        check(tag, "valid", plan_valid_o, 1);
        check(tag, "chunk", chunk_o, ch);
        check(tag, "burst_len", burst_len_o, bu);
        check("R6", "burst_cnt", burst_cnt_o, cn);
        check("R7", "remain", remain_o, rem - ch);
        check("R7", "done", done_o, (rem == ch) ? 1 : 0);
        checks++;
        if (remain_o == 1) begin
            errors++;
            $display("FAIL R10 tail: actual 1 expected not 1");
        end
    endtask

    task automatic run_transfer(input int unsigned tot, input int unsigned fifo);
        fifo_depth_i = DEPTH_W'(fifo);
        do_load(tot);
        check("R7", "remain after load", remain_o, tot);
        for (int n = 0; n < 20 && !done_o; n++) plan_and_check();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; load_i = 1'b0; start_i = 1'b0; total_i = '0; fifo_depth_i = 8'd16;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R7", "reset done", done_o, 1);
        check("R7", "reset remain", remain_o, 0);
        check("R9", "reset busy", busy_o, 0);
        check("R8", "reset err", err_o, 0);

        // R9: start with nothing remaining is ignored
        do_start();
        check("R9", "no valid when empty", plan_valid_o, 0);
        check("R9", "busy when empty", busy_o, 0);

        // R8: too-short totals
        do_load(1);
        check("R8", "err len1", err_o, 1);
        check("R8", "done len1", done_o, 1);
        check("R8", "remain len1", remain_o, 0);
        do_load(0);
        check("R8", "err len0", err_o, 1);
        do_load(2);
        check("R8", "err cleared", err_o, 0);
        check("R8", "remain len2", remain_o, 2);
        // R8: load wins over simultaneous start
        @(negedge clk); load_i = 1'b1; start_i = 1'b1; total_i = 24'd30;
        @(negedge clk); load_i = 1'b0; start_i = 1'b0;
        check("R8", "load priority remain", remain_o, 30);
        check("R8", "load priority valid", plan_valid_o, 0);

        // R1 with latency
        fifo_depth_i = 8'd64;
        do_load(40);
        do_start();
        check("R1", "immediate valid", plan_valid_o, 1);
        check("R1", "chunk", chunk_o, 40);
        check("R6", "count", burst_cnt_o, 1);

        // R9: busy during search, load and start ignored while busy
        fifo_depth_i = 8'd4;
        do_load(11);
        do_start();
        check("R9", "busy in search", busy_o, 1);
        @(negedge clk); load_i = 1'b1; start_i = 1'b1; total_i = 24'd100;
        @(negedge clk); load_i = 1'b0; start_i = 1'b0;
        check("R9", "remain held while busy", remain_o, 11);
        wait_valid();
        check("R5", "fallback chunk", chunk_o, 8);
        check("R9", "load ignored", remain_o, 3);
        @(posedge clk); #1;
        check("R9", "busy cleared", busy_o, 0);
        plan_and_check();

        run_transfer(17, 4);      // R5 tail-of-one then R4 burst 3
        run_transfer(600, 32);    // R4 burst 8
        run_transfer(343, 16);    // R4 burst 7
        run_transfer(MAXC + 1, 32);      // R3
        run_transfer(MAXC + 5, 32);      // R2
        run_transfer(2 * MAXC + 1, 32);  // R2 then R3

        for (int i = 0; i < 60; i++) begin
            int unsigned tot, sel;
            sel = $urandom_range(0, 9);
            if (sel < 7)      tot = $urandom_range(2, 2000);
            else if (sel < 9) tot = $urandom_range(MAXC - 40, MAXC + 40);
            else              tot = $urandom_range(2, 2 * MAXC);
            run_transfer(tot, $urandom_range(4, 64));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule